// File: doc/BRIEF.md
# Guarded Peripheral Bridge

This block sits between one master port of the system interconnect and a simple peripheral bus. The peripheral bus serves a fixed number of equal-sized slots. The block maps an address window onto those slots and drives a one-hot module select for the addressed slot. It runs the access as one peripheral transfer and returns ready, error and read data to the master.

Every request is screened once, in the cycle it is accepted. The screen uses a three-bit protection set for the target slot (supervisor-only, no-write, trusted-only), a per-master privilege-enable bit and the slot's configured data width. An address outside the window, or one that selects an unimplemented slot, is also rejected. A rejected request returns an error response and starts no peripheral transfer.

The request side is a valid/ready channel. `m_req_ready` is high only while the bridge is idle. A master raising `m_req_valid` must hold all request fields stable until it sees ready high at a clock edge. Once a request is accepted, ready stays low until its response has been given. The response side has no back-pressure: `m_rsp_valid` is a single-cycle pulse that the master must take when it appears. On the peripheral side, select and strobe are held until the slave raises `s_ready`.

Top module: `pbg_bridge`

## Requirements
- R1: `m_req_ready` is high only in idle. Each accepted request yields exactly one response pulse. `m_rsp_valid` lasts one cycle, and ready stays low from the cycle after acceptance through the response cycle.
- R2: A clean access to implemented slot k (address bits [15:12] equal k, bits [31:16] equal 0x4000) drives `s_sel` with bit k alone, together with `s_strobe`, from the cycle after acceptance. `s_offset` carries address bits [11:0], and `s_write`, `s_size` and `s_wdata` carry the request fields.
- R3: If bit 2 (supervisor-only) of the slot's set is 1, the access is rejected unless `m_req_super` is 1 and the privilege-enable bit indexed by `m_req_mid` is 1.
- R4: If bit 1 (no-write) of the slot's set is 1, any write is rejected and reads proceed.
- R5: If bit 0 (trusted-only) of the slot's set is 1, any access with `m_req_trusted` equal to 0 is rejected.
- R6: Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = invalid. The slot width uses the same codes (default: slots 0–7 are 32-bit, slot 8 is 16-bit, slot 9 is 8-bit). An access is rejected when its size code exceeds the slot's width code. Address alignment is never checked.
- R7: An address outside the window, or one that selects a slot number at or above NUM_SLOTS, is rejected.
- R8: A rejected access gets `m_rsp_valid` and `m_rsp_err` high together in the cycle after acceptance. It asserts no select bit and no strobe at any time.
- R9: A clean access gives exactly one peripheral transfer. Select, strobe, offset and data are held while `s_ready` is low, and strobe drops in the cycle after `s_ready` is seen. The response comes one cycle after that edge.
- R10: A clean response returns the `s_rdata` value sampled with `s_ready`. An error response returns zero data.
- R11: Config index j < 2 holds the sets of slots 8j..8j+7, with 4 bits per slot (slot 8j+n at bits [4n+2:4n], bit 4n+3 reserved). Reserved bits and the bits of unimplemented slots read 0 and ignore writes. Index 2 holds the privilege-enable bits, bit m for master m, with bits 31:8 reading 0. Index 3 reads 0. All registers reset to 0, and reads are combinational.
- R12: The screen uses register values from before the acceptance edge. A config write on that same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Config write enable |
| cfg_idx | input | 2 | Config register index |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for `cfg_idx` |
| m_req_valid | input | 1 | Request valid |
| m_req_ready | output | 1 | Request ready (idle) |
| m_req_addr | input | 32 | Request byte address |
| m_req_write | input | 1 | 1 = write, 0 = read |
| m_req_size | input | 2 | Access size code |
| m_req_wdata | input | 32 | Write data |
| m_req_super | input | 1 | Master in supervisor mode |
| m_req_trusted | input | 1 | Master is trusted |
| m_req_mid | input | 3 | Master number |
| m_rsp_valid | output | 1 | Response pulse |
| m_rsp_err | output | 1 | Error, only with `m_rsp_valid` |
| m_rsp_rdata | output | 32 | Read data, valid with `m_rsp_valid` |
| s_sel | output | 10 | One-hot module selects |
| s_strobe | output | 1 | Peripheral transfer strobe |
| s_write | output | 1 | Peripheral write direction |
| s_size | output | 2 | Peripheral access size code |
| s_offset | output | 12 | Byte offset inside the slot |
| s_wdata | output | 32 | Peripheral write data |
| s_rdata | input | 32 | Peripheral read data |
| s_ready | input | 1 | Peripheral transfer complete |

## Verification
The overlap that matters is a protection-register write landing on the same edge that accepts a request to the slot that write changes. The bench drives a write that sets no-write on slot 5 in the same cycle as a write request to slot 5. It expects that request to complete cleanly with one transfer, and a second write to slot 5 straight after to be rejected with no select seen. A bridge that screened with the freshly written value would fail the first half; one that never updated would fail the second.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } bridge_state_e;

  // per-slot protection set, MSB first
  typedef struct packed {
    logic sup;   // supervisor-only
    logic wp;    // no-write
    logic tp;    // trusted-only
  } prot_bits_t;

  typedef struct packed {
    logic unmapped;
    logic priv;
    logic wr;
    logic trust;
    logic size;
  } viol_t;

endpackage

// File: rtl/pbg_prot_regs.sv
module pbg_prot_regs #(
  parameter int NUM_SLOTS   = 10,
  parameter int NUM_MASTERS = 8,
  parameter int PROT_REGS   = 2,
  parameter int CFG_IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_IDX_W-1:0]          cfg_idx,
  input  logic [31:0]                   cfg_wdata,
  output logic [31:0]                   cfg_rdata,
  output logic [NUM_SLOTS-1:0][2:0]     slot_prot,
  output logic [NUM_MASTERS-1:0]        priv_en
);

  localparam int PAD_SLOTS = PROT_REGS * 8;

  logic [NUM_SLOTS-1:0][2:0]   prot_q;
  logic [NUM_MASTERS-1:0]      priv_q;
  logic [PAD_SLOTS-1:0][2:0]   prot_pad;
  logic                        unused_wbits;

  assign unused_wbits = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
    end else if (cfg_we) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cfg_idx == CFG_IDX_W'(s / 8))
          prot_q[s] <= cfg_wdata[4*(s%8) +: 3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      priv_q <= '0;
    else if (cfg_we && cfg_idx == CFG_IDX_W'(PROT_REGS))
      priv_q <= cfg_wdata[NUM_MASTERS-1:0];
  end

  generate
    for (genvar g = 0; g < PAD_SLOTS; g++) begin : g_pad
      if (g < NUM_SLOTS) begin : g_real
        assign prot_pad[g] = prot_q[g];
      end else begin : g_none
        assign prot_pad[g] = 3'b000;
      end
    end
  endgenerate

  always_comb begin
    cfg_rdata = '0;
    for (int r = 0; r < PROT_REGS; r++) begin
      if (cfg_idx == CFG_IDX_W'(r)) begin
        for (int n = 0; n < 8; n++)
          cfg_rdata[4*n +: 3] = prot_pad[r*8+n];
      end
    end
    if (cfg_idx == CFG_IDX_W'(PROT_REGS))
      cfg_rdata[NUM_MASTERS-1:0] = priv_q;
  end

  assign slot_prot = prot_q;
  assign priv_en   = priv_q;

  // R11: registers change only on a config write
  p_prot_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(prot_q));
  p_priv_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(priv_q));

endmodule

// File: rtl/pbg_addr_decode.sv
module pbg_addr_decode #(
  parameter int          NUM_SLOTS = 10,
  parameter int          SLOT_AW   = 12,
  parameter int          WIN_BITS  = 4,
  parameter logic [31:0] WIN_BASE  = 32'h4000_0000
) (
  input  logic [31:SLOT_AW]      addr_hi,
  output logic [NUM_SLOTS-1:0]   sel,
  output logic                   hit
);

  localparam int WIN_LSB = SLOT_AW + WIN_BITS;

  logic                in_win;
  logic [WIN_BITS-1:0] pos;

  assign in_win = (addr_hi[31:WIN_LSB] == WIN_BASE[31:WIN_LSB]);
  assign pos    = addr_hi[WIN_LSB-1:SLOT_AW];

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
      assign sel[s] = in_win && (pos == WIN_BITS'(s));
    end
  endgenerate

  assign hit = |sel;

endmodule

// File: rtl/pbg_access_check.sv
module pbg_access_check
  import pbg_pkg::*;
#(
  parameter int                     NUM_SLOTS   = 10,
  parameter int                     NUM_MASTERS = 8,
  parameter int                     MID_W       = 3,
  parameter logic [2*NUM_SLOTS-1:0] SLOT_SIZES  = 20'h1_AAAA
) (
  input  logic [NUM_SLOTS-1:0]       sel,
  input  logic                       hit,
  input  logic [NUM_SLOTS-1:0][2:0]  slot_prot,
  input  logic [NUM_MASTERS-1:0]     priv_en,
  input  logic [1:0]                 size,
  input  logic                       write,
  input  logic                       super_mode,
  input  logic                       trusted,
  input  logic [MID_W-1:0]           mid,
  output viol_t                      viol,
  output logic                       fail
);

  prot_bits_t p;
  logic [1:0] wcode;
  logic       priv_ok;

  // AND-OR pick of the selected slot's set and width
  always_comb begin
    p     = '0;
    wcode = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (sel[s]) begin
        p     = prot_bits_t'(p | slot_prot[s]);
        wcode = wcode | SLOT_SIZES[2*s +: 2];
      end
    end
  end

  assign priv_ok = priv_en[mid];

  always_comb begin
    viol.unmapped = !hit;
    viol.priv     = hit && p.sup && !(super_mode && priv_ok);
    viol.wr       = hit && p.wp && write;
    viol.trust    = hit && p.tp && !trusted;
    viol.size     = hit && (size > wcode);
  end

  assign fail = |viol;

endmodule

// File: rtl/pbg_bridge.sv
module pbg_bridge
  import pbg_pkg::*;
#(
  parameter int          NUM_SLOTS   = 10,
  parameter int          SLOT_AW     = 12,
  parameter int          WIN_BITS    = 4,
  parameter logic [31:0] WIN_BASE    = 32'h4000_0000,
  parameter int          NUM_MASTERS = 8,
  parameter logic [2*NUM_SLOTS-1:0] SLOT_SIZES = 20'h1_AAAA,
  localparam int MID_W     = $clog2(NUM_MASTERS),
  localparam int PROT_REGS = (NUM_SLOTS + 7) / 8,
  localparam int CFG_IDX_W = $clog2(PROT_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_IDX_W-1:0]  cfg_idx,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  input  logic                  m_req_valid,
  output logic                  m_req_ready,
  input  logic [31:0]           m_req_addr,
  input  logic                  m_req_write,
  input  logic [1:0]            m_req_size,
  input  logic [31:0]           m_req_wdata,
  input  logic                  m_req_super,
  input  logic                  m_req_trusted,
  input  logic [MID_W-1:0]      m_req_mid,
  output logic                  m_rsp_valid,
  output logic                  m_rsp_err,
  output logic [31:0]           m_rsp_rdata,
  output logic [NUM_SLOTS-1:0]  s_sel,
  output logic                  s_strobe,
  output logic                  s_write,
  output logic [1:0]            s_size,
  output logic [SLOT_AW-1:0]    s_offset,
  output logic [31:0]           s_wdata,
  input  logic [31:0]           s_rdata,
  input  logic                  s_ready
);

  bridge_state_e               state_q;
  logic [NUM_SLOTS-1:0]        dec_sel;
  logic                        dec_hit;
  logic [NUM_SLOTS-1:0][2:0]   slot_prot;
  logic [NUM_MASTERS-1:0]      priv_en;
  viol_t                       viol;
  logic                        fail;
  logic                        accept;

  logic [NUM_SLOTS-1:0]        lat_sel;
  logic                        lat_write;
  logic [1:0]                  lat_size;
  logic [SLOT_AW-1:0]          lat_off;
  logic [31:0]                 lat_wdata;
  logic                        err_q;
  logic [31:0]                 rdata_q;

  pbg_prot_regs #(
    .NUM_SLOTS   (NUM_SLOTS),
    .NUM_MASTERS (NUM_MASTERS),
    .PROT_REGS   (PROT_REGS),
    .CFG_IDX_W   (CFG_IDX_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .slot_prot (slot_prot),
    .priv_en   (priv_en)
  );

  pbg_addr_decode #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_AW   (SLOT_AW),
    .WIN_BITS  (WIN_BITS),
    .WIN_BASE  (WIN_BASE)
  ) u_dec (
    .addr_hi (m_req_addr[31:SLOT_AW]),
    .sel     (dec_sel),
    .hit     (dec_hit)
  );

  pbg_access_check #(
    .NUM_SLOTS   (NUM_SLOTS),
    .NUM_MASTERS (NUM_MASTERS),
    .MID_W       (MID_W),
    .SLOT_SIZES  (SLOT_SIZES)
  ) u_chk (
    .sel        (dec_sel),
    .hit        (dec_hit),
    .slot_prot  (slot_prot),
    .priv_en    (priv_en),
    .size       (m_req_size),
    .write      (m_req_write),
    .super_mode (m_req_super),
    .trusted    (m_req_trusted),
    .mid        (m_req_mid),
    .viol       (viol),
    .fail       (fail)
  );

  assign m_req_ready = (state_q == ST_IDLE);
  assign accept      = m_req_valid && m_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lat_sel   <= '0;
      lat_write <= 1'b0;
      lat_size  <= '0;
      lat_off   <= '0;
      lat_wdata <= '0;
      err_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            lat_sel   <= dec_sel;
            lat_write <= m_req_write;
            lat_size  <= m_req_size;
            lat_off   <= m_req_addr[SLOT_AW-1:0];
            lat_wdata <= m_req_wdata;
            if (fail) begin
              err_q   <= 1'b1;
              rdata_q <= '0;
              state_q <= ST_RESP;
            end else begin
              err_q   <= 1'b0;
              state_q <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (s_ready) begin
            rdata_q <= s_rdata;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign s_strobe    = (state_q == ST_XFER);
  assign s_sel       = s_strobe ? lat_sel : '0;
  assign s_write     = lat_write;
  assign s_size      = lat_size;
  assign s_offset    = lat_off;
  assign s_wdata     = lat_wdata;
  assign m_rsp_valid = (state_q == ST_RESP);
  assign m_rsp_err   = m_rsp_valid && err_q;
  assign m_rsp_rdata = rdata_q;

  // R1
  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_valid |=> !m_rsp_valid);
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !m_req_ready);
  // R2
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_strobe |-> $onehot(s_sel));
  // R7
  p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !dec_hit |=> m_rsp_valid && m_rsp_err);
  // R8
  p_err_nostrobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_err |-> !$past(s_strobe));
  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_strobe && !s_ready |=> s_strobe && $stable(s_sel) && $stable(s_offset));
  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_strobe && s_ready |=> !s_strobe && m_rsp_valid);
  // R10
  p_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_valid && !m_rsp_err |-> m_rsp_rdata == $past(s_rdata));
  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_err |-> m_rsp_rdata == 32'h0);

endmodule

// File: tb/pbg_bridge_tb_top.sv
`timescale 1ns/1ps
module pbg_bridge_tb_top;

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  sz;
    logic        sup;
    logic        tr;
    logic [2:0]  mid;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{32'h4000_0010, 1'b0, 2'd2, 1'b0, 1'b0, 3'd1, 1'b0, 4'd2},  // R2 open slot 0
    '{32'h4000_0003, 1'b1, 2'd0, 1'b0, 1'b0, 3'd1, 1'b0, 4'd6},  // R6 misaligned byte
    '{32'h4000_0101, 1'b1, 2'd1, 1'b0, 1'b0, 3'd1, 1'b0, 4'd6},  // R6 misaligned half
    '{32'h4000_1004, 1'b0, 2'd2, 1'b1, 1'b0, 3'd0, 1'b0, 4'd3},  // R3 sup + enabled
    '{32'h4000_1004, 1'b0, 2'd2, 1'b1, 1'b0, 3'd1, 1'b1, 4'd3},  // R3 master not enabled
    '{32'h4000_1008, 1'b0, 2'd2, 1'b0, 1'b1, 3'd0, 1'b1, 4'd3},  // R3 user mode
    '{32'h4000_2000, 1'b0, 2'd2, 1'b0, 1'b0, 3'd3, 1'b0, 4'd4},  // R4 read ok
    '{32'h4000_2000, 1'b1, 2'd2, 1'b0, 1'b0, 3'd3, 1'b1, 4'd4},  // R4 write rejected
    '{32'h4000_3010, 1'b0, 2'd1, 1'b0, 1'b1, 3'd4, 1'b0, 4'd5},  // R5 trusted ok
    '{32'h4000_3010, 1'b0, 2'd1, 1'b1, 1'b0, 3'd0, 1'b1, 4'd5},  // R5 untrusted
    '{32'h4000_4020, 1'b0, 2'd2, 1'b1, 1'b1, 3'd2, 1'b0, 4'd3},  // R3 all bits, read ok
    '{32'h4000_4020, 1'b1, 2'd2, 1'b1, 1'b1, 3'd2, 1'b1, 4'd4},  // R4 all bits, write
    '{32'h4000_8002, 1'b1, 2'd1, 1'b0, 1'b0, 3'd5, 1'b0, 4'd6},  // R6 half on 16-bit
    '{32'h4000_8004, 1'b0, 2'd2, 1'b0, 1'b0, 3'd5, 1'b1, 4'd6},  // R6 word on 16-bit
    '{32'h4000_9FFF, 1'b0, 2'd0, 1'b0, 1'b0, 3'd6, 1'b0, 4'd6},  // R6 byte on 8-bit
    '{32'h4000_9FFE, 1'b0, 2'd1, 1'b0, 1'b0, 3'd6, 1'b1, 4'd6},  // R6 half on 8-bit
    '{32'h4000_0000, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 1'b1, 4'd6},  // R6 invalid size
    '{32'h4000_C000, 1'b0, 2'd2, 1'b1, 1'b1, 3'd0, 1'b1, 4'd7},  // R7 empty slot
    '{32'h4001_0000, 1'b0, 2'd2, 1'b1, 1'b1, 3'd0, 1'b1, 4'd7},  // R7 outside window
    '{32'h4000_5ABC, 1'b1, 2'd2, 1'b0, 1'b0, 3'd7, 1'b0, 4'd2}   // R2 open slot 5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        m_req_valid = 1'b0;
  logic        m_req_ready;
  logic [31:0] m_req_addr = '0;
  logic        m_req_write = 1'b0;
  logic [1:0]  m_req_size = '0;
  logic [31:0] m_req_wdata = '0;
  logic        m_req_super = 1'b0;
  logic        m_req_trusted = 1'b0;
  logic [2:0]  m_req_mid = '0;
  logic        m_rsp_valid;
  logic        m_rsp_err;
  logic [31:0] m_rsp_rdata;
  logic [9:0]  s_sel;
  logic        s_strobe;
  logic        s_write;
  logic [1:0]  s_size;
  logic [11:0] s_offset;
  logic [31:0] s_wdata;
  logic [31:0] s_rdata;
  logic        s_ready = 1'b0;

  always #2.5 clk = ~clk;

  pbg_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_addr(m_req_addr),
    .m_req_write(m_req_write), .m_req_size(m_req_size), .m_req_wdata(m_req_wdata),
    .m_req_super(m_req_super), .m_req_trusted(m_req_trusted), .m_req_mid(m_req_mid),
    .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err), .m_rsp_rdata(m_rsp_rdata),
    .s_sel(s_sel), .s_strobe(s_strobe), .s_write(s_write), .s_size(s_size),
    .s_offset(s_offset), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ready(s_ready)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // peripheral model: completes after slv_delay extra strobe cycles
  int          slv_delay = 0;
  int          strobe_cyc = 0;
  int          xfer_cnt = 0;
  logic [9:0]  sel_or = '0;
  logic [9:0]  last_sel = '0;
  logic [11:0] last_off = '0;
  logic        last_wr = 1'b0;
  logic [1:0]  last_sz = '0;
  logic [31:0] last_wdata = '0;

  assign s_rdata = {20'hC3A50, s_offset};

  always @(negedge clk) begin
    sel_or = sel_or | s_sel;
    if (s_strobe) begin
      if (strobe_cyc == slv_delay) begin
        s_ready    = 1'b1;
        xfer_cnt   = xfer_cnt + 1;
        last_sel   = s_sel;
        last_off   = s_offset;
        last_wr    = s_write;
        last_sz    = s_size;
        last_wdata = s_wdata;
      end else begin
        s_ready = 1'b0;
      end
      strobe_cyc = strobe_cyc + 1;
    end else begin
      s_ready    = 1'b0;
      strobe_cyc = 0;
    end
  end

  task automatic cfg_write(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input logic [1:0] idx, input logic [31:0] exp, input string what);
    @(negedge clk);
    cfg_idx = idx;
    #0.5;
    chk(cfg_rdata === exp, "R11", what, cfg_rdata, exp);
  endtask

  task automatic do_access(input vec_t v, input int delay, input logic [31:0] wd,
                           input string req, input bit with_cfg, input logic [31:0] cfg_d);
    int   xf0;
    int   cyc;
    int   exp_cyc;
    logic [9:0] exp_sel;
    @(negedge clk);
    chk(m_req_ready === 1'b1, "R1", "ready while idle", {31'b0, m_req_ready}, 32'h1);
    m_req_addr = v.addr; m_req_write = v.wr; m_req_size = v.sz;
    m_req_super = v.sup; m_req_trusted = v.tr; m_req_mid = v.mid;
    m_req_wdata = wd; m_req_valid = 1'b1;
    if (with_cfg) begin
      cfg_we = 1'b1; cfg_idx = 2'd0; cfg_wdata = cfg_d;
    end
    slv_delay = delay; xf0 = xfer_cnt; sel_or = '0;
    @(negedge clk);
    m_req_valid = 1'b0; cfg_we = 1'b0;
    chk(m_req_ready === 1'b0, "R1", "ready low while busy", {31'b0, m_req_ready}, 32'h0);
    cyc = 1;
    while (m_rsp_valid !== 1'b1 && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    exp_cyc = v.err ? 1 : delay + 2;
    chk(cyc == exp_cyc, v.err ? "R8" : "R9", "response latency", cyc, exp_cyc);
    chk(m_rsp_err === v.err, req, "error flag", {31'b0, m_rsp_err}, {31'b0, v.err});
    if (v.err) begin
      chk(xfer_cnt == xf0, "R8", "no transfer on error", xfer_cnt - xf0, 0);
      chk(sel_or == '0, "R8", "no select on error", {22'b0, sel_or}, 32'h0);
      chk(m_rsp_rdata === 32'h0, "R10", "error data zero", m_rsp_rdata, 32'h0);
    end else begin
      exp_sel = 10'(1 << v.addr[15:12]);
      chk(xfer_cnt == xf0 + 1, "R9", "one transfer", xfer_cnt - xf0, 1);
      chk(last_sel === exp_sel, "R2", "module select", {22'b0, last_sel}, {22'b0, exp_sel});
      chk(last_off === v.addr[11:0], "R2", "offset", {20'b0, last_off}, {20'b0, v.addr[11:0]});
      chk(last_wr === v.wr && last_sz === v.sz, "R2", "dir/size",
          {29'b0, last_wr, last_sz}, {29'b0, v.wr, v.sz});
      if (v.wr)
        chk(last_wdata === wd, "R2", "write data", last_wdata, wd);
      else
        chk(m_rsp_rdata === {20'hC3A50, v.addr[11:0]}, "R10", "read data",
            m_rsp_rdata, {20'hC3A50, v.addr[11:0]});
    end
    @(negedge clk);
    chk(m_rsp_valid === 1'b0, "R1", "response one cycle", {31'b0, m_rsp_valid}, 32'h0);
    chk(m_req_ready === 1'b1, "R1", "ready back", {31'b0, m_req_ready}, 32'h1);
  endtask

  initial begin
    #750000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // reset state, R1 R2 R11
    chk(m_req_ready === 1'b1, "R1", "ready in reset", {31'b0, m_req_ready}, 32'h1);
    chk(m_rsp_valid === 1'b0, "R1", "no response in reset", {31'b0, m_rsp_valid}, 32'h0);
    chk(s_strobe === 1'b0 && s_sel === '0, "R2", "bus idle in reset", {22'b0, s_sel}, 32'h0);
    rst_n = 1'b1;
    cfg_check(2'd0, 32'h0, "reset idx0");
    cfg_check(2'd2, 32'h0, "reset priv");

    // R11: reserved bits and absent slots are dropped
    cfg_write(2'd0, 32'h888F_9AC8);
    cfg_write(2'd1, 32'hFFFF_FF00);
    cfg_write(2'd2, 32'hFFFF_FF05);
    cfg_write(2'd3, 32'hFFFF_FFFF);
    cfg_check(2'd0, 32'h0007_1240, "idx0 readback");
    cfg_check(2'd1, 32'h0000_0000, "idx1 readback");
    cfg_check(2'd2, 32'h0000_0005, "priv readback");
    cfg_check(2'd3, 32'h0000_0000, "idx3 reads zero");

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      do_access(v, i % 3, 32'hDA7A_0000 | i, $sformatf("R%0d", v.req), 1'b0, 32'h0);
    end

    // R12: no-write set on slot 5 on the same edge as a write to slot 5
    v = '{32'h4000_5010, 1'b1, 2'd2, 1'b0, 1'b0, 3'd1, 1'b0, 4'd12};
    do_access(v, 1, 32'h1234_5678, "R12", 1'b1, 32'h0027_1240);
    v.err = 1'b1;
    do_access(v, 0, 32'h1234_5679, "R12", 1'b0, 32'h0);
    v.wr = 1'b0; v.err = 1'b0;
    do_access(v, 0, 32'h0, "R12", 1'b0, 32'h0);

    // R3: clear privilege of master 0, supervisor access to slot 1 now rejected
    cfg_write(2'd2, 32'h0000_0004);
    v = '{32'h4000_1000, 1'b0, 2'd2, 1'b1, 1'b1, 3'd0, 1'b1, 4'd3};
    do_access(v, 0, 32'h0, "R3", 1'b0, 32'h0);

    // R9: long slave stall keeps transfer single
    v = '{32'h4000_6044, 1'b0, 2'd2, 1'b0, 1'b0, 3'd0, 1'b0, 4'd9};
    do_access(v, 5, 32'h0, "R9", 1'b0, 32'h0);

    report();
    $finish;
  end

endmodule